// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two 16-bit buses, A and B, and is split into two 8-bit halves that each have their own controls. Each half holds two storage registers: one loads from the A bus and one loads from the B bus. Each register loads on the rising edge of its own capture strobe. The bus being driven can carry either the live value from the other bus or the value held in the register.

A per-half active-low output enable and a direction input choose which bus, if any, the half drives. With the enable high the half is isolated and drives neither bus, but both registers can still load. Each tri-state pin is modelled as three signals: an input, an output and an output-enable.

The capture strobes are ordinary signals that the system clock samples. A register loads on the clock edge where its strobe is first seen high.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Reset (rst_ni low) clears every storage register to zero. Reading a half in stored mode just after reset gives 0x00.
- R2: In each half, the A register loads that half's bits of a_i on the clock edge where the half's cap_ab_i bit is first seen high. This happens whatever the state of oe_ni and dir_i. A strobe held high does not load again.
- R3: In each half, the B register loads that half's bits of b_i on the clock edge where the half's cap_ba_i bit is first seen high. This happens whatever the state of oe_ni and dir_i.
- R4: With oe_ni high, a half drives neither bus: a_oe_o and b_oe_o are 0 for that half, and its register loading still takes place.
- R5: With oe_ni low, dir_i=1 sets b_oe_o and clears a_oe_o for the half. dir_i=0 does the reverse. The two enables of one half are never both set.
- R6: When B is driven and sel_ab_i=0, the half's bits of b_o equal the live bits of a_i, with no clock edge needed.
- R7: When B is driven and sel_ab_i=1, the half's bits of b_o equal the A register. A value loaded on an edge appears on b_o right after that edge.
- R8: When A is driven, sel_ba_i selects between live b_i (0) and the B register (1) for a_o, in the same way as R6 and R7.
- R9: Half 0 (bits 7:0) uses bit 0 of each control and half 1 (bits 15:8) uses bit 1. Neither half reacts to the other half's controls.
- R10: Any output bits whose enable is 0 are driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | A bus pin input |
| a_o | output | 16 | A bus pin output value |
| a_oe_o | output | 2 | A bus drive enable, one bit per half |
| b_i | input | 16 | B bus pin input |
| b_o | output | 16 | B bus pin output value |
| b_oe_o | output | 2 | B bus drive enable, one bit per half |
| oe_ni | input | 2 | Output enable per half, active low |
| dir_i | input | 2 | Direction per half, 1 = A to B |
| cap_ab_i | input | 2 | A register capture strobe per half |
| cap_ba_i | input | 2 | B register capture strobe per half |
| sel_ab_i | input | 2 | B output source per half, 1 = stored |
| sel_ba_i | input | 2 | A output source per half, 1 = stored |

## Verification
A register load and a stored-mode output of that same register can happen in the same cycle. The bench provokes this by raising a capture strobe while the half is already driving from storage. It checks that the old value is still on the output before the edge and that the new value is there right after it. The bench also makes the two halves load in opposite directions within one cycle, so that any crossing between the halves would show on the outputs.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned HALVES  = 2;
  localparam int unsigned SLICE_W = BUS_W / HALVES;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/bxr_edge_det.sv
module bxr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  // reset high so a strobe held high through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

  // R2
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bxr_store.sv
module bxr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         load;
  logic [W-1:0] q_q;

  bxr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cap_i),
    .rise_o (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (load) q_q <= d_i;
  end

  assign q_o = q_q;

  // R2
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> q_o == $past(d_i));
  // R2
  hold_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(q_o));
endmodule

// File: rtl/bxr_slice.sv
module bxr_slice
  import bxr_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         a_oe_o,
  output logic         b_oe_o,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i
);
  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] to_b, to_a;
  src_e         src_ab, src_ba;

  bxr_store #(.W(W)) u_store_a (
    .clk_i (clk_i), .rst_ni (rst_ni), .cap_i (cap_ab_i), .d_i (a_i), .q_o (reg_a)
  );
  bxr_store #(.W(W)) u_store_b (
    .clk_i (clk_i), .rst_ni (rst_ni), .cap_i (cap_ba_i), .d_i (b_i), .q_o (reg_b)
  );

  assign src_ab = src_e'(sel_ab_i);
  assign src_ba = src_e'(sel_ba_i);

  always_comb begin
    to_b = (src_ab == SRC_STORED) ? reg_a : a_i;
    to_a = (src_ba == SRC_STORED) ? reg_b : b_i;
  end

  assign b_oe_o = ~oe_ni &  dir_i;
  assign a_oe_o = ~oe_ni & ~dir_i;
  assign b_o    = b_oe_o ? to_b : '0;
  assign a_o    = a_oe_o ? to_a : '0;

  // R5
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));
  // R4
  iso_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o && b_o == '0 && a_o == '0));
  // R7
  stored_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && sel_ab_i && $past(cap_ab_i) && !$past(cap_ab_i, 2) && $past(rst_ni, 2))
      |-> b_o == $past(a_i));
  // R8
  stored_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && sel_ba_i && $past(cap_ba_i) && !$past(cap_ba_i, 2) && $past(rst_ni, 2))
      |-> a_o == $past(b_i));
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import bxr_pkg::*;
#(
  parameter int unsigned WIDTH = BUS_W,
  parameter int unsigned NHALF = HALVES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic [NHALF-1:0] a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic [NHALF-1:0] b_oe_o,
  input  logic [NHALF-1:0] oe_ni,
  input  logic [NHALF-1:0] dir_i,
  input  logic [NHALF-1:0] cap_ab_i,
  input  logic [NHALF-1:0] cap_ba_i,
  input  logic [NHALF-1:0] sel_ab_i,
  input  logic [NHALF-1:0] sel_ba_i
);
  localparam int unsigned SW = WIDTH / NHALF;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    bxr_slice #(.W(SW)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_i      (a_i[h*SW +: SW]),
      .b_i      (b_i[h*SW +: SW]),
      .a_o      (a_o[h*SW +: SW]),
      .b_o      (b_o[h*SW +: SW]),
      .a_oe_o   (a_oe_o[h]),
      .b_oe_o   (b_oe_o[h]),
      .oe_ni    (oe_ni[h]),
      .dir_i    (dir_i[h]),
      .cap_ab_i (cap_ab_i[h]),
      .cap_ba_i (cap_ba_i[h]),
      .sel_ab_i (sel_ab_i[h]),
      .sel_ba_i (sel_ba_i[h])
    );
  end

  // R9
  half_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_oe_o | b_oe_o) & oe_ni) == '0);
endmodule

// File: tb/reg_bus_xcvr_tb_top.sv
module reg_bus_xcvr_tb_top;
  localparam time PER = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [15:0] a_o, b_o;
  logic [1:0]  a_oe, b_oe;
  logic [1:0]  oe_n = 2'b11, dir = '0, cab = '0, cba = '0, sab = '0, sba = '0;
  int total = 0, bad = 0;

  always #(PER/2) clk = ~clk;

  reg_bus_xcvr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe), .oe_ni(oe_n), .dir_i(dir),
    .cap_ab_i(cab), .cap_ba_i(cba), .sel_ab_i(sab), .sel_ba_i(sba)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cab = '0; cba = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  // R1: both stores read back zero in stored mode after reset
  task automatic t_reset();
    do_reset();
    chk("R4", "a_oe iso", {14'd0, a_oe}, 16'h0);
    chk("R4", "b_oe iso", {14'd0, b_oe}, 16'h0);
    oe_n = 2'b00; dir = 2'b11; sab = 2'b11;
    #1;
    chk("R1", "b_o stored A", b_o, 16'h0000);
    chk("R5", "b_oe dir1", {14'd0, b_oe}, 16'h0003);
    chk("R5", "a_oe dir1", {14'd0, a_oe}, 16'h0000);
    dir = 2'b00; sba = 2'b11;
    #1;
    chk("R1", "a_o stored B", a_o, 16'h0000);
  endtask

  // R6 R8 R9 R10: halves transparent in opposite directions
  task automatic t_live();
    oe_n = 2'b00; dir = 2'b01; sab = 2'b00; sba = 2'b00;
    a_i = 16'h5A3C; b_i = 16'hC3A5;
    #1;
    chk("R6", "b_o live h0", b_o, 16'h003C);
    chk("R8", "a_o live h1", a_o, 16'hC300);
    chk("R9", "b_oe split", {14'd0, b_oe}, 16'h0001);
    chk("R9", "a_oe split", {14'd0, a_oe}, 16'h0002);
    a_i = 16'h5AE1;
    #1;
    chk("R6", "b_o follows a_i", b_o, 16'h00E1);
  endtask

  // R4 R2 R3: loading while isolated
  task automatic t_isolate();
    oe_n = 2'b11; a_i = 16'h1122; b_i = 16'h3344;
    cab = 2'b11; cba = 2'b11;
    step();
    cab = 2'b00; cba = 2'b00;
    chk("R4", "a_o iso", a_o, 16'h0);
    chk("R4", "b_o iso", b_o, 16'h0);
    chk("R10", "oe both off", {12'd0, a_oe, b_oe}, 16'h0);
    a_i = 16'hFFFF; b_i = 16'hFFFF;
    oe_n = 2'b00; dir = 2'b01; sab = 2'b11; sba = 2'b11;
    step();
    chk("R2", "b_o h0 stored", b_o, 16'h0022);
    chk("R3", "a_o h1 stored", a_o, 16'h3300);
    dir = 2'b10;
    #1;
    chk("R2", "b_o h1 stored", b_o, 16'h1100);
    chk("R3", "a_o h0 stored", a_o, 16'h0044);
  endtask

  // R7 R8: load and stored output on the same edge
  task automatic t_same_edge();
    dir = 2'b01; sab = 2'b11; sba = 2'b11;
    a_i = 16'h0077; b_i = 16'h8800;
    cab = 2'b01; cba = 2'b10;
    #1;
    chk("R7", "b_o before edge", b_o, 16'h0022);
    chk("R8", "a_o before edge", a_o, 16'h3300);
    step();
    chk("R7", "b_o after edge", b_o, 16'h0077);
    chk("R8", "a_o after edge", a_o, 16'h8800);
    // R2: strobe held high does not load again
    a_i = 16'hAAAA;
    step();
    chk("R2", "held strobe", b_o, 16'h0077);
    cab = 2'b00; cba = 2'b00;
    step();
  endtask

  // R2 R3 R9: loading ignores direction and enable, per half
  task automatic t_any_mode();
    oe_n = 2'b10; dir = 2'b00;
    a_i = 16'h005E; b_i = 16'h6F00;
    cab = 2'b01; cba = 2'b10;
    step();
    cab = 2'b00; cba = 2'b00;
    chk("R9", "h1 off h0 drives A", {14'd0, a_oe}, 16'h0001);
    oe_n = 2'b00; dir = 2'b01; sab = 2'b01; sba = 2'b10;
    a_i = 16'h0000; b_i = 16'h0000;
    step();
    chk("R2", "h0 A reg", b_o, 16'h005E);
    chk("R3", "h1 B reg", a_o, 16'h6F00);
  endtask

  task automatic t_reset_again();
    do_reset();
    oe_n = 2'b00; dir = 2'b11; sab = 2'b11;
    #1;
    chk("R1", "clear after run", b_o, 16'h0000);
  endtask

  initial begin
    #(PER * 50000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_live();
    t_isolate();
    t_same_edge();
    t_any_mode();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule